// File: doc/BRIEF.md
# Parallel Camera Pixel Capture

This block takes pixels from an image sensor that marks lines and frames with separate horizontal and vertical sync wires. It runs in the fabric clock domain and oversamples the sensor pixel clock. On the selected edge of that clock it samples the 12-bit data bus and both sync lines, and packs the pixels into 32-bit words for a downstream FIFO. While a frame is being captured it also emits one-cycle event pulses for frame start, frame end, line start and line end.

Static configuration inputs select the data width, the order of pixels within a word, the sampling edge, the sync polarities and the way acquisition starts. Other inputs enable or disable capture, immediately or at the end of the current frame, and clear the internal state while the block is disabled. All decisions are taken on sampling edges, so "immediately" means at the next sampling edge of the pixel clock.

Top module: `cam_par_capture`

## Requirements
- R1: With `cfg_clk_pol` = 0 data is taken on the rising edge of `pclk_in`. With 1 it is taken on the falling edge. Data present only at the opposite edge is never captured.
- R2: `cfg_hs_pol` and `cfg_vs_pol` each set the active level of their sync line: 0 means active high and 1 means active low.
- R3: Width code 3'b000 selects 8-bit pixels, bits [7:0] of the bus. Four pixels form one word, and without swap the first pixel lands in word bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R4: Width codes 3'b001 (10-bit, bus bits [9:0]) and 3'b010 (12-bit, bus bits [11:0]) pack two pixels per word. Each pixel is zero-extended in its own 16-bit half, and without swap the first pixel lands in bits [15:0].
- R5: With `cfg_swap` = 1 the pixel order within each word is reversed: the first pixel lands in the highest slot.
- R6: Every other width code (3'b011 and above) is reserved: no pixel is accepted and no word is produced. Sync events still occur.
- R7: With `cfg_start_edge` = 0 an enabled block starts capture at any sampling edge where VSYNC is active. With 1 it starts only on an inactive-to-active VSYNC transition seen at two consecutive sampling edges.
- R8: `evt_frame_start` pulses when capture begins. `evt_frame_end` pulses when VSYNC goes inactive during capture. `evt_line_start` and `evt_line_end` pulse on HSYNC active and inactive transitions, and only during capture. Every pulse and every `word_valid` is one clock wide and appears in the clock after the sampling edge.
- R9: At frame end a partly filled word is output, with its unused slots zero.
- R10: When `cfg_en` is low and `cfg_frame_trig` is 0, capture stops at the next sampling edge. The partial word is dropped, and no frame end or line end event occurs.
- R11: When `cfg_en` is low and `cfg_frame_trig` is 1, capture continues until the frame ends, including the frame end flush, and no further frame is started.
- R12: `cfg_fsm_rst` clears the capture state, the packer and the sync history (so an active VSYNC looks new to the edge start mode), but only while `cfg_en` is low. While `cfg_en` is high it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, faster than twice the pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_in | input | 1 | Sensor pixel clock, already in the `clk` domain |
| pix_in | input | 12 | Sensor data bus |
| hsync_in | input | 1 | Horizontal sync line |
| vsync_in | input | 1 | Vertical sync line |
| cfg_en | input | 1 | Capture enable |
| cfg_frame_trig | input | 1 | Defer disabling to frame end |
| cfg_start_edge | input | 1 | 1: start only on a VSYNC activating edge |
| cfg_clk_pol | input | 1 | Sampling edge select |
| cfg_hs_pol | input | 1 | HSYNC polarity, 1 means active low |
| cfg_vs_pol | input | 1 | VSYNC polarity, 1 means active low |
| cfg_width | input | 3 | Pixel width code |
| cfg_swap | input | 1 | Reverse the pixel order within a word |
| cfg_fsm_rst | input | 1 | State clear, honoured while disabled |
| word_valid | output | 1 | Packed word strobe |
| word_data | output | 32 | Packed word |
| evt_frame_start | output | 1 | Frame start pulse |
| evt_frame_end | output | 1 | Frame end pulse |
| evt_line_start | output | 1 | Line start pulse |
| evt_line_end | output | 1 | Line end pulse |

## Verification
The assertions assume that width, swap and polarity settings do not change during a frame, since a word's layout is judged against the width code of the clock before it. They also assume that `pclk_in` toggles no faster than every other fabric clock. The stimulus changes configuration only while capture is off, after idle sampling edges that drive both sync lines at their inactive level for the new polarity. It holds each pixel clock phase for two fabric clocks.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

  typedef enum logic {
    ST_OFF  = 1'b0,
    ST_CAPT = 1'b1
  } cap_state_t;

  localparam logic [2:0] WMODE_8  = 3'd0;
  localparam logic [2:0] WMODE_10 = 3'd1;
  localparam logic [2:0] WMODE_12 = 3'd2;

  localparam int NARROW_BITS = 8;
  localparam int MID_BITS    = 10;

endpackage

// File: rtl/cam_pclk_edge.sv
// Detects the selected pixel clock edge in the fabric clock domain.
module cam_pclk_edge (
  input  logic clk,
  input  logic rst,
  input  logic pclk_in,
  input  logic cfg_clk_pol,
  output logic samp
);
  logic pclk_q;

  always_ff @(posedge clk) begin
    if (rst) pclk_q <= 1'b0;
    else     pclk_q <= pclk_in;
  end

  always_comb begin
    if (cfg_clk_pol) samp = pclk_q & ~pclk_in;
    else             samp = ~pclk_q & pclk_in;
  end
endmodule

// File: rtl/cam_frame_ctrl.sv
// Sync tracking, acquisition state and event generation.
module cam_frame_ctrl
  import cam_cap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic samp,
  input  logic hsync_in,
  input  logic vsync_in,
  input  logic cfg_en,
  input  logic cfg_frame_trig,
  input  logic cfg_start_edge,
  input  logic cfg_hs_pol,
  input  logic cfg_vs_pol,
  input  logic cfg_fsm_rst,
  input  logic width_ok,
  output logic pk_push,
  output logic pk_flush,
  output logic pk_clear,
  output logic evt_frame_start,
  output logic evt_frame_end,
  output logic evt_line_start,
  output logic evt_line_end
);
  cap_state_t st, st_n;
  logic vs_q, hs_q;
  logic vs_a, hs_a, vs_rise, vs_fall, hs_rise, hs_fall;
  logic fs_n, fe_n, ls_n, le_n;
  logic soft_clr;

  assign soft_clr = cfg_fsm_rst & ~cfg_en;

  always_comb begin
    vs_a     = vsync_in ^ cfg_vs_pol;
    hs_a     = hsync_in ^ cfg_hs_pol;
    vs_rise  = vs_a & ~vs_q;
    vs_fall  = ~vs_a & vs_q;
    hs_rise  = hs_a & ~hs_q;
    hs_fall  = ~hs_a & hs_q;
    st_n     = st;
    fs_n     = 1'b0;
    fe_n     = 1'b0;
    ls_n     = 1'b0;
    le_n     = 1'b0;
    pk_push  = 1'b0;
    pk_flush = 1'b0;
    pk_clear = soft_clr;
    if (samp) begin
      case (st)
        ST_OFF: begin
          if (cfg_en && (cfg_start_edge ? vs_rise : vs_a)) begin
            st_n = ST_CAPT;
            fs_n = 1'b1;
          end
        end
        ST_CAPT: begin
          if (!cfg_en && !cfg_frame_trig) begin
            st_n     = ST_OFF;
            pk_clear = 1'b1;
          end else if (vs_fall) begin
            st_n     = ST_OFF;
            fe_n     = 1'b1;
            le_n     = hs_fall;
            pk_flush = 1'b1;
          end else begin
            ls_n    = hs_rise;
            le_n    = hs_fall;
            pk_push = hs_a & width_ok;
          end
        end
        default: st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      st              <= ST_OFF;
      vs_q            <= 1'b0;
      hs_q            <= 1'b0;
      evt_frame_start <= 1'b0;
      evt_frame_end   <= 1'b0;
      evt_line_start  <= 1'b0;
      evt_line_end    <= 1'b0;
    end else begin
      if (samp) begin
        vs_q <= vs_a;
        hs_q <= hs_a;
      end
      st              <= st_n;
      evt_frame_start <= fs_n;
      evt_frame_end   <= fe_n;
      evt_line_start  <= ls_n;
      evt_line_end    <= le_n;
    end
  end
endmodule

// File: rtl/cam_pix_pack.sv
// Packs pixels into output words, with optional order reversal.
module cam_pix_pack
  import cam_cap_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PIX_W-1:0]  pix,
  input  logic              flush,
  input  logic              clear,
  input  logic [2:0]        cfg_width,
  input  logic              cfg_swap,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  localparam int NARROW_SLOTS = WORD_W / 8;
  localparam int WIDE_SLOTS   = WORD_W / 16;
  localparam int CNT_W        = $clog2(NARROW_SLOTS);

  logic [WORD_W-1:0] acc, acc_n, pix_ext;
  logic [CNT_W:0]    cnt, nsl, idx;
  logic              last;
  int                shamt;

  always_comb begin
    nsl  = (cfg_width == WMODE_8) ? (CNT_W+1)'(NARROW_SLOTS) : (CNT_W+1)'(WIDE_SLOTS);
    last = (cnt == nsl - 1'b1);
    idx  = cfg_swap ? (nsl - 1'b1 - cnt) : cnt;
    pix_ext = '0;
    case (cfg_width)
      WMODE_8:  pix_ext[NARROW_BITS-1:0] = pix[NARROW_BITS-1:0];
      WMODE_10: pix_ext[MID_BITS-1:0]    = pix[MID_BITS-1:0];
      default:  pix_ext[PIX_W-1:0]       = pix;
    endcase
    shamt = (cfg_width == WMODE_8) ? int'(idx) * 8 : int'(idx) * 16;
    acc_n = acc | (pix_ext << shamt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      cnt        <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (clear) begin
        acc <= '0;
        cnt <= '0;
      end else if (push) begin
        if (last) begin
          word_data  <= acc_n;
          word_valid <= 1'b1;
          acc        <= '0;
          cnt        <= '0;
        end else begin
          acc <= acc_n;
          cnt <= cnt + 1'b1;
        end
      end else if (flush && cnt != '0) begin
        word_data  <= acc;
        word_valid <= 1'b1;
        acc        <= '0;
        cnt        <= '0;
      end
    end
  end
endmodule

// File: rtl/cam_par_capture.sv
module cam_par_capture
  import cam_cap_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pclk_in,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              cfg_en,
  input  logic              cfg_frame_trig,
  input  logic              cfg_start_edge,
  input  logic              cfg_clk_pol,
  input  logic              cfg_hs_pol,
  input  logic              cfg_vs_pol,
  input  logic [2:0]        cfg_width,
  input  logic              cfg_swap,
  input  logic              cfg_fsm_rst,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              evt_frame_start,
  output logic              evt_frame_end,
  output logic              evt_line_start,
  output logic              evt_line_end
);
  logic samp, width_ok, pk_push, pk_flush, pk_clear;

  assign width_ok = (cfg_width == WMODE_8) || (cfg_width == WMODE_10) ||
                    (cfg_width == WMODE_12);

  cam_pclk_edge u_edge (
    .clk         (clk),
    .rst         (rst),
    .pclk_in     (pclk_in),
    .cfg_clk_pol (cfg_clk_pol),
    .samp        (samp)
  );

  cam_frame_ctrl u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .samp            (samp),
    .hsync_in        (hsync_in),
    .vsync_in        (vsync_in),
    .cfg_en          (cfg_en),
    .cfg_frame_trig  (cfg_frame_trig),
    .cfg_start_edge  (cfg_start_edge),
    .cfg_hs_pol      (cfg_hs_pol),
    .cfg_vs_pol      (cfg_vs_pol),
    .cfg_fsm_rst     (cfg_fsm_rst),
    .width_ok        (width_ok),
    .pk_push         (pk_push),
    .pk_flush        (pk_flush),
    .pk_clear        (pk_clear),
    .evt_frame_start (evt_frame_start),
    .evt_frame_end   (evt_frame_end),
    .evt_line_start  (evt_line_start),
    .evt_line_end    (evt_line_end)
  );

  cam_pix_pack #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .push       (pk_push),
    .pix        (pix_in),
    .flush      (pk_flush),
    .clear      (pk_clear),
    .cfg_width  (cfg_width),
    .cfg_swap   (cfg_swap),
    .word_valid (word_valid),
    .word_data  (word_data)
  );
endmodule

// File: rtl/cam_par_capture_chk.sv
module cam_par_capture_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic [2:0]        cfg_width,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic              evt_frame_start,
  input logic              evt_frame_end,
  input logic              evt_line_start,
  input logic              evt_line_end
);
  function automatic logic [WORD_W-1:0] hi_mask10();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++)
      if ((i % 16) >= 10) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] HI10 = hi_mask10();

  logic in_frame;
  always_ff @(posedge clk) begin
    if (rst)                  in_frame <= 1'b0;
    else if (evt_frame_start) in_frame <= 1'b1;
    else if (evt_frame_end)   in_frame <= 1'b0;
  end

  a_r8_fs_single: assert property (@(posedge clk) disable iff (rst)
    evt_frame_start |=> !evt_frame_start);

  a_r8_fs_fe_excl: assert property (@(posedge clk) disable iff (rst)
    !(evt_frame_start && evt_frame_end));

  a_r8_line_in_frame: assert property (@(posedge clk) disable iff (rst)
    (evt_line_start || evt_line_end) |-> in_frame);

  a_r9_word_in_frame: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> in_frame);

  a_r6_no_reserved_word: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ($past(cfg_width) <= 3'd2));

  a_r4_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (word_valid && $past(cfg_width) == 3'd1) |-> ((word_data & HI10) == '0));

  a_r7_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    evt_frame_start |-> $past(cfg_en));
endmodule

bind cam_par_capture cam_par_capture_chk #(.WORD_W(WORD_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_en          (cfg_en),
  .cfg_width       (cfg_width),
  .word_valid      (word_valid),
  .word_data       (word_data),
  .evt_frame_start (evt_frame_start),
  .evt_frame_end   (evt_frame_end),
  .evt_line_start  (evt_line_start),
  .evt_line_end    (evt_line_end)
);

// File: tb/cam_par_capture_bench.sv
`timescale 1ns/1ps
module cam_par_capture_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pclk_in = 1'b0;
  logic [11:0] pix_in = '0;
  logic        hsync_in = 1'b0, vsync_in = 1'b0;
  logic        cfg_en = 1'b0, cfg_frame_trig = 1'b0, cfg_start_edge = 1'b0;
  logic        cfg_clk_pol = 1'b0, cfg_hs_pol = 1'b0, cfg_vs_pol = 1'b0;
  logic [2:0]  cfg_width = 3'd0;
  logic        cfg_swap = 1'b0, cfg_fsm_rst = 1'b0;
  logic        word_valid;
  logic [31:0] word_data;
  logic        evt_frame_start, evt_frame_end, evt_line_start, evt_line_end;

  always #5 clk = ~clk;

  cam_par_capture u_cam_par_capture (
    .clk(clk), .rst(rst), .pclk_in(pclk_in), .pix_in(pix_in),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .cfg_en(cfg_en),
    .cfg_frame_trig(cfg_frame_trig), .cfg_start_edge(cfg_start_edge),
    .cfg_clk_pol(cfg_clk_pol), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
    .cfg_width(cfg_width), .cfg_swap(cfg_swap), .cfg_fsm_rst(cfg_fsm_rst),
    .word_valid(word_valid), .word_data(word_data),
    .evt_frame_start(evt_frame_start), .evt_frame_end(evt_frame_end),
    .evt_line_start(evt_line_start), .evt_line_end(evt_line_end)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_words = 0, n_fs = 0, n_fe = 0, n_ls = 0, n_le = 0;
  int b_words, b_fs, b_fe, b_ls, b_le;
  logic [31:0] got [0:63];
  bit done = 0;

  // Collector, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid) begin got[n_words % 64] = word_data; n_words++; end
      if (evt_frame_start) n_fs++;
      if (evt_frame_end)   n_fe++;
      if (evt_line_start)  n_ls++;
      if (evt_line_end)    n_le++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic snap();
    b_words = n_words; b_fs = n_fs; b_fe = n_fe; b_ls = n_ls; b_le = n_le;
  endtask

  function automatic logic [11:0] pv(input int seed, input int k);
    return 12'(seed + k * 315);
  endfunction

  // Expected word built from R3, R4 and R5.
  function automatic logic [31:0] exp_word(input int wm, input bit sw, input int npix,
                                           input int widx, input int seed);
    int ns  = (wm == 0) ? 4 : 2;
    int sz  = (wm == 0) ? 8 : 16;
    int msk = (wm == 0) ? 255 : ((wm == 1) ? 1023 : 4095);
    logic [31:0] w = '0;
    for (int k = widx * ns; k < (widx + 1) * ns && k < npix; k++) begin
      int slot = k % ns;
      int pos  = sw ? (ns - 1 - slot) : slot;
      w |= 32'(int'(pv(seed, k)) & msk) << (pos * sz);
    end
    return w;
  endfunction

  // One pixel clock period; junk data sits at the non-sampling edge (R1).
  task automatic pxl(input logic [11:0] d, input logic h_act, input logic v_act);
    logic lvl;
    lvl = ~cfg_clk_pol;
    @(negedge clk);
    pclk_in  = ~lvl;
    pix_in   = ~d;
    hsync_in = h_act ^ cfg_hs_pol;
    vsync_in = v_act ^ cfg_vs_pol;
    repeat (2) @(negedge clk);
    pclk_in = lvl;
    pix_in  = d;
    repeat (2) @(negedge clk);
  endtask

  task automatic pixels(input int seed, input int from, input int cnt);
    for (int k = from; k < from + cnt; k++) pxl(pv(seed, k), 1'b1, 1'b1);
  endtask

  task automatic frame(input int seed, input int npix);
    pxl(12'h0, 1'b0, 1'b0);
    pxl(12'h0, 1'b0, 1'b0);
    pxl(12'h0, 1'b0, 1'b1);
    pixels(seed, 0, npix);
    pxl(12'h0, 1'b0, 1'b1);
    pxl(12'h0, 1'b0, 1'b0);
    pxl(12'h0, 1'b0, 1'b0);
  endtask

  // Fields: [15:12] expected words, [11:9] width, [8] swap, [7] clk pol,
  // [6] hs pol, [5] vs pol, [4:0] pixel count.
  localparam logic [15:0] VEC [0:5] = '{
    {4'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd8},
    {4'd2, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd6},
    {4'd2, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd4},
    {4'd2, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 5'd3},
    {4'd3, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 5'd5},
    {4'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 5'd4}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    check_eq("R8 reset word_valid", 32'(word_valid), 32'd0);
    check_eq("R8 reset events", 32'({evt_frame_start, evt_frame_end, evt_line_start, evt_line_end}), 32'd0);
    check_eq("R3 reset word_data", word_data, 32'd0);

    // Table walk: R1 edges, R2 polarities, R3/R4 widths, R5 swap, R6 reserved, R9 flush.
    for (int r = 0; r < 6; r++) begin
      int seed, wm, npix, expn;
      string tag;
      seed = 'h5A3 + r * 'h101;
      wm   = int'(VEC[r][11:9]);
      npix = int'(VEC[r][4:0]);
      expn = int'(VEC[r][15:12]);
      tag  = (wm == 0) ? "R3" : ((wm > 2) ? "R6" : "R4");
      cfg_en = 1'b0;
      @(negedge clk);
      cfg_width   = VEC[r][11:9];
      cfg_swap    = VEC[r][8];
      cfg_clk_pol = VEC[r][7];
      cfg_hs_pol  = VEC[r][6];
      cfg_vs_pol  = VEC[r][5];
      pxl(12'h0, 1'b0, 1'b0);
      pxl(12'h0, 1'b0, 1'b0);
      cfg_fsm_rst = 1'b1;
      @(negedge clk);
      cfg_fsm_rst = 1'b0;
      cfg_en = 1'b1;
      snap();
      frame(seed, npix);
      check_eq({tag, " word count"}, 32'(n_words - b_words), 32'(expn));
      for (int w = 0; w < expn; w++)
        check_eq({tag, "/R5/R1/R9 word"}, got[(b_words + w) % 64],
                 exp_word(wm, VEC[r][8], npix, w, seed));
      check_eq("R8/R2 frame events", 32'((n_fs - b_fs) * 16 + (n_fe - b_fe)), 32'h11);
      check_eq("R8/R2 line events",  32'((n_ls - b_ls) * 16 + (n_le - b_le)), 32'h11);
    end

    // Directed tests with 8-bit, no swap, active-high syncs, rising edge.
    cfg_en = 1'b0;
    @(negedge clk);
    cfg_width = 3'd0; cfg_swap = 1'b0; cfg_clk_pol = 1'b0;
    cfg_hs_pol = 1'b0; cfg_vs_pol = 1'b0; cfg_frame_trig = 1'b0;

    // R7 level start while VSYNC already active
    cfg_start_edge = 1'b0;
    pxl(12'h0, 1'b0, 1'b1);
    pxl(12'h0, 1'b0, 1'b1);
    snap();
    cfg_en = 1'b1;
    pxl(12'h0, 1'b0, 1'b1);
    check_eq("R7 level start fs", 32'(n_fs - b_fs), 32'd1);
    pixels('h111, 0, 4);
    pxl(12'h0, 1'b0, 1'b1);
    pxl(12'h0, 1'b0, 1'b0);
    check_eq("R7 level start words", 32'(n_words - b_words), 32'd1);
    check_eq("R7 level start data", got[b_words % 64], exp_word(0, 0, 4, 0, 'h111));

    // R7 edge start: active VSYNC at enable does not start
    cfg_en = 1'b0;
    cfg_start_edge = 1'b1;
    pxl(12'h0, 1'b0, 1'b1);
    pxl(12'h0, 1'b0, 1'b1);
    snap();
    cfg_en = 1'b1;
    pxl(12'h0, 1'b0, 1'b1);
    pixels('h222, 0, 4);
    pxl(12'h0, 1'b0, 1'b1);
    pxl(12'h0, 1'b0, 1'b0);
    check_eq("R7 edge no start fs", 32'(n_fs - b_fs), 32'd0);
    check_eq("R7 edge no start words", 32'(n_words - b_words), 32'd0);
    check_eq("R8 no line events outside capture", 32'(n_ls - b_ls + n_le - b_le), 32'd0);
    check_eq("R8 no frame end outside capture", 32'(n_fe - b_fe), 32'd0);
    snap();
    frame('h333, 4);
    check_eq("R7 edge start fs", 32'(n_fs - b_fs), 32'd1);
    check_eq("R7 edge start data", got[b_words % 64], exp_word(0, 0, 4, 0, 'h333));

    // R12 state clear while disabled makes an active VSYNC look new
    cfg_en = 1'b0;
    pxl(12'h0, 1'b0, 1'b1);
    pxl(12'h0, 1'b0, 1'b1);
    cfg_fsm_rst = 1'b1;
    @(negedge clk);
    cfg_fsm_rst = 1'b0;
    cfg_en = 1'b1;
    snap();
    pxl(12'h0, 1'b0, 1'b1);
    check_eq("R12 clear then edge start", 32'(n_fs - b_fs), 32'd1);
    pixels('h444, 0, 4);
    pxl(12'h0, 1'b0, 1'b0);
    check_eq("R12 clear then data", got[b_words % 64], exp_word(0, 0, 4, 0, 'h444));

    // R12 clear ignored while enabled
    snap();
    pxl(12'h0, 1'b0, 1'b0);
    pxl(12'h0, 1'b0, 1'b1);
    pixels('h555, 0, 2);
    cfg_fsm_rst = 1'b1;
    @(negedge clk);
    cfg_fsm_rst = 1'b0;
    pixels('h555, 2, 2);
    pxl(12'h0, 1'b0, 1'b1);
    pxl(12'h0, 1'b0, 1'b0);
    check_eq("R12 ignored when enabled words", 32'(n_words - b_words), 32'd1);
    check_eq("R12 ignored when enabled data", got[b_words % 64], exp_word(0, 0, 4, 0, 'h555));
    check_eq("R12 ignored when enabled fe", 32'(n_fe - b_fe), 32'd1);

    // R10 immediate stop
    cfg_start_edge = 1'b0;
    cfg_frame_trig = 1'b0;
    snap();
    pxl(12'h0, 1'b0, 1'b0);
    pxl(12'h0, 1'b0, 1'b1);
    pixels('h666, 0, 3);
    cfg_en = 1'b0;
    pixels('h666, 3, 3);
    pxl(12'h0, 1'b0, 1'b1);
    pxl(12'h0, 1'b0, 1'b0);
    check_eq("R10 immediate stop words", 32'(n_words - b_words), 32'd0);
    check_eq("R10 immediate stop fe", 32'(n_fe - b_fe), 32'd0);
    check_eq("R10 immediate stop le", 32'(n_le - b_le), 32'd0);

    // R11 deferred stop at frame end
    cfg_en = 1'b1;
    cfg_frame_trig = 1'b1;
    pxl(12'h0, 1'b0, 1'b0);
    snap();
    pxl(12'h0, 1'b0, 1'b1);
    pixels('h777, 0, 3);
    cfg_en = 1'b0;
    pixels('h777, 3, 3);
    pxl(12'h0, 1'b0, 1'b1);
    pxl(12'h0, 1'b0, 1'b0);
    check_eq("R11 deferred words", 32'(n_words - b_words), 32'd2);
    check_eq("R11 deferred word0", got[b_words % 64], exp_word(0, 0, 6, 0, 'h777));
    check_eq("R11/R9 deferred flushed word1", got[(b_words + 1) % 64], exp_word(0, 0, 6, 1, 'h777));
    check_eq("R11 deferred fe", 32'(n_fe - b_fe), 32'd1);
    snap();
    frame('h888, 4);
    check_eq("R11 no restart fs", 32'(n_fs - b_fs), 32'd0);
    check_eq("R11 no restart words", 32'(n_words - b_words), 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule